// File: doc/BRIEF.md
# Low-Frequency Register Crossing Bank with Batched Release

This block keeps a small bank of configuration registers that software writes on a fast bus clock and that take effect on a slow, fully asynchronous low-frequency clock. Each write is held in a fast-side shadow register. The shadow value is then carried to the slow side by a toggle request/acknowledge handshake, with two-flop synchronizers in each direction. While a register's value is in transit, its busy flag is high. A second write to that register holds the ready signal low until the flag clears. Writes to other registers are not held up.

A freeze control lets software stage updates to several registers and make them take effect together. The freeze request takes effect only after every busy flag is clear. While freeze is in effect, writes only update the shadows and mark the registers as pending. Repeated writes to one register do not stall, and the last value wins. When the freeze request drops, all pending registers cross through one shared handshake. The slow side loads all of them on the same slow-clock edge.

Top module: `lf_sync_bank`

## Requirements
- R1: After reset, every slow-side register output is zero, every busy flag is clear, the frozen status is low and the write port is ready.
- R2: An accepted write to a register outside freeze sets that register's busy flag on the next fast-clock edge. The slow-side output takes the written value only after at least one slow-clock edge, and the busy flag clears once the crossing has finished.
- R3: A write aimed at a register whose busy flag is set, outside freeze, holds the ready output low until that flag clears. The held write then completes, and the slow side ends with its value.
- R4: A write to a register whose busy flag is clear is accepted at once, even while another register's crossing is in flight.
- R5: When the freeze request rises, the frozen status stays low while any busy flag is set. The frozen status is never high while a busy flag is set.
- R6: While frozen, writes are accepted without stalling, busy flags stay clear and the slow-side outputs do not change.
- R7: When the freeze request drops while frozen, the ready output is low for that cycle. On the next fast edge, exactly the registers written during the freeze become busy. Their last written values appear on the slow side on one common slow-clock edge, and unwritten registers keep their values. If no register was written, no busy flag rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fclk | input | 1 | Fast bus clock |
| sclk | input | 1 | Slow low-frequency clock, asynchronous to fclk |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| wr_en | input | 1 | Write request, fast domain |
| wr_idx | input | IDX_W (2) | Register index of the write |
| wr_data | input | DW (32) | Write data |
| wr_ready | output | 1 | Write accepted on the fclk edge when wr_en and wr_ready are both high |
| freeze_req | input | 1 | Level request for freeze mode |
| frozen | output | 1 | Freeze in effect |
| busy | output | NREG (4) | Per-register crossing-in-progress flags |
| s_regs | output | NREG*DW (128) | Slow-side register values; register i at bits [i*DW +: DW] |

## Verification
The bench builds the block with its default four registers of 32 bits. It runs the fast clock at 10 ns and the slow clock at an unrelated 74 ns period, so each crossing spans many fast cycles. That makes the stall window, the overlap of one register's crossing with a write to another, and the wait before freeze is granted all wide enough to probe at fast-clock resolution. With four registers, a release can carry a non-adjacent subset (first and last). A slow-clock monitor then confirms that both members of that subset load on one shared slow edge, while the two untouched registers in between stay unchanged.

// File: rtl/lfs_pkg.sv
package lfs_pkg;
    localparam int LFS_NREG = 4;
    localparam int LFS_DW   = 32;
    // synchronizer stages per direction
    localparam int LFS_SYNC_STAGES = 2;
endpackage

// File: rtl/lfs_sync.sv
module lfs_sync #(
    parameter int W      = 1,
    parameter int STAGES = lfs_pkg::LFS_SYNC_STAGES
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/lfs_fast_ctrl.sv
module lfs_fast_ctrl #(
    parameter int NREG  = lfs_pkg::LFS_NREG,
    parameter int DW    = lfs_pkg::LFS_DW,
    parameter int IDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic                      fclk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic [DW-1:0]             wr_data,
    input  logic                      freeze_req,
    input  logic [NREG-1:0]           ack_s,
    input  logic                      grp_ack_s,
    output logic                      wr_ready,
    output logic                      frozen,
    output logic [NREG-1:0]           busy,
    output logic [NREG-1:0][DW-1:0]   shadow,
    output logic [NREG-1:0]           req_t,
    output logic                      grp_req,
    output logic [NREG-1:0]           grp_mask
);
    typedef struct packed {
        logic [NREG-1:0][DW-1:0] shadow;
        logic [NREG-1:0]         req_t;
        logic [NREG-1:0]         pend;
        logic [NREG-1:0]         grp_mask;
        logic                    grp_req;
        logic                    frozen;
    } fast_st_t;

    fast_st_t st_d, st_q;
    logic [NREG-1:0] chan_busy;
    logic            grp_busy;
    logic            hold, release_now, idx_ok, accept;

    always_comb begin
        chan_busy   = st_q.req_t ^ ack_s;
        grp_busy    = st_q.grp_req ^ grp_ack_s;
        busy        = chan_busy | ({NREG{grp_busy}} & st_q.grp_mask);
        hold        = st_q.frozen && freeze_req;
        release_now = st_q.frozen && !freeze_req;
        idx_ok      = int'(wr_idx) < NREG;
        wr_ready    = !release_now && idx_ok && (hold || !busy[wr_idx]);
        accept      = wr_en && wr_ready;

        st_d = st_q;
        if (accept) begin
            st_d.shadow[wr_idx] = wr_data;
            if (hold) st_d.pend[wr_idx]  = 1'b1;
            else      st_d.req_t[wr_idx] = ~st_q.req_t[wr_idx];
        end
        if (release_now) begin
            st_d.frozen = 1'b0;
            st_d.pend   = '0;
            if (|st_q.pend) begin
                st_d.grp_mask = st_q.pend;
                st_d.grp_req  = ~st_q.grp_req;
            end
        end else if (freeze_req && !st_q.frozen && (busy == '0) && !accept) begin
            st_d.frozen = 1'b1;
        end
    end

    always_ff @(posedge fclk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign frozen   = st_q.frozen;
    assign shadow   = st_q.shadow;
    assign req_t    = st_q.req_t;
    assign grp_req  = st_q.grp_req;
    assign grp_mask = st_q.grp_mask;

    p_busy_set_r2: assert property (@(posedge fclk) disable iff (!rst_n)
        (wr_en && wr_ready && !st_q.frozen) |=> busy[$past(wr_idx)]);

    p_stall_keeps_shadow_r3: assert property (@(posedge fclk) disable iff (!rst_n)
        (wr_en && !wr_ready) |=> $stable(st_q.shadow));

    p_frozen_idle_r5: assert property (@(posedge fclk) disable iff (!rst_n)
        st_q.frozen |-> (busy == '0));

    p_frozen_no_stall_r6: assert property (@(posedge fclk) disable iff (!rst_n)
        (st_q.frozen && freeze_req && wr_en && idx_ok) |-> wr_ready);

    p_release_mask_r7: assert property (@(posedge fclk) disable iff (!rst_n)
        (st_q.frozen && !freeze_req) |=> (busy == $past(st_q.pend)));
endmodule

// File: rtl/lfs_slow_bank.sv
module lfs_slow_bank #(
    parameter int NREG = lfs_pkg::LFS_NREG,
    parameter int DW   = lfs_pkg::LFS_DW
) (
    input  logic                    sclk,
    input  logic                    rst_n,
    input  logic [NREG-1:0]         req_s,
    input  logic                    grp_s,
    input  logic [NREG-1:0]         grp_mask,
    input  logic [NREG-1:0][DW-1:0] shadow,
    output logic [NREG-1:0]         ack_t,
    output logic                    grp_ack,
    output logic [NREG-1:0][DW-1:0] regs
);
    typedef struct packed {
        logic [NREG-1:0][DW-1:0] regs;
        logic [NREG-1:0]         ack_t;
        logic                    grp_ack;
    } slow_st_t;

    slow_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NREG; i++) begin
            if (req_s[i] != st_q.ack_t[i]) begin
                st_d.regs[i]  = shadow[i];
                st_d.ack_t[i] = req_s[i];
            end
        end
        if (grp_s != st_q.grp_ack) begin
            for (int i = 0; i < NREG; i++) begin
                if (grp_mask[i]) st_d.regs[i] = shadow[i];
            end
            st_d.grp_ack = grp_s;
        end
    end

    always_ff @(posedge sclk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ack_t   = st_q.ack_t;
    assign grp_ack = st_q.grp_ack;
    assign regs    = st_q.regs;

    // slow outputs move only when a synchronized request is outstanding (R2)
    p_load_on_request_r2: assert property (@(posedge sclk) disable iff (!rst_n)
        ((req_s == st_q.ack_t) && (grp_s == st_q.grp_ack)) |=> $stable(st_q.regs));
endmodule

// File: rtl/lf_sync_bank.sv
module lf_sync_bank #(
    parameter int NREG  = lfs_pkg::LFS_NREG,
    parameter int DW    = lfs_pkg::LFS_DW,
    parameter int IDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic                 fclk,
    input  logic                 sclk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [DW-1:0]        wr_data,
    output logic                 wr_ready,
    input  logic                 freeze_req,
    output logic                 frozen,
    output logic [NREG-1:0]      busy,
    output logic [NREG*DW-1:0]   s_regs
);
    localparam int TW = NREG + 1;

    logic [NREG-1:0][DW-1:0] shadow, regs;
    logic [NREG-1:0]         req_t, grp_mask, ack_t;
    logic                    grp_req, grp_ack;
    logic [TW-1:0]           fwd_s, back_s;

    lfs_fast_ctrl #(.NREG(NREG), .DW(DW), .IDX_W(IDX_W)) u_fast (
        .fclk(fclk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .freeze_req(freeze_req),
        .ack_s(back_s[NREG-1:0]), .grp_ack_s(back_s[NREG]),
        .wr_ready(wr_ready), .frozen(frozen), .busy(busy),
        .shadow(shadow), .req_t(req_t), .grp_req(grp_req), .grp_mask(grp_mask)
    );

    lfs_sync #(.W(TW)) u_to_slow (
        .clk(sclk), .rst_n(rst_n), .d({grp_req, req_t}), .q(fwd_s)
    );

    lfs_sync #(.W(TW)) u_to_fast (
        .clk(fclk), .rst_n(rst_n), .d({grp_ack, ack_t}), .q(back_s)
    );

    lfs_slow_bank #(.NREG(NREG), .DW(DW)) u_slow (
        .sclk(sclk), .rst_n(rst_n),
        .req_s(fwd_s[NREG-1:0]), .grp_s(fwd_s[NREG]),
        .grp_mask(grp_mask), .shadow(shadow),
        .ack_t(ack_t), .grp_ack(grp_ack), .regs(regs)
    );

    assign s_regs = regs;
endmodule

// File: tb/test_lf_sync_bank.sv
module test_lf_sync_bank;
    localparam int NREG = 4;
    localparam int DW   = 32;

    logic fclk = 1'b0, sclk = 1'b0, rst_n = 1'b0;
    logic wr_en = 1'b0, freeze_req = 1'b0;
    logic [1:0] wr_idx = '0;
    logic [DW-1:0] wr_data = '0;
    logic wr_ready, frozen;
    logic [NREG-1:0] busy;
    logic [NREG*DW-1:0] s_regs;

    int errors = 0, checks = 0;
    int scyc = 0;
    int chg0 = -1, chg3 = -1;
    logic [DW-1:0] prev0 = '0, prev3 = '0;
    bit done = 0;

    always #5  fclk = ~fclk;
    always #37 sclk = ~sclk;

    lf_sync_bank i_lf_sync_bank (
        .fclk(fclk), .sclk(sclk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .wr_ready(wr_ready),
        .freeze_req(freeze_req), .frozen(frozen), .busy(busy), .s_regs(s_regs)
    );

    function automatic logic [DW-1:0] sreg(int i);
        return s_regs[i*DW +: DW];
    endfunction

    // slow-side change monitor for simultaneity of the batched release
    always @(negedge sclk) begin
        scyc++;
        if (sreg(0) != prev0) chg0 = scyc;
        if (sreg(3) != prev3) chg3 = scyc;
        prev0 = sreg(0);
        prev3 = sreg(3);
    end

    task automatic check(string req, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_write(int idx, logic [DW-1:0] data, output int stalls);
        stalls = 0;
        @(negedge fclk);
        wr_en = 1'b1; wr_idx = idx[1:0]; wr_data = data;
        #1;
        while (!wr_ready) begin
            stalls++;
            @(negedge fclk); #1;
        end
        @(posedge fclk); #1;
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        @(negedge fclk);
        while (busy != '0 && n < 2000) begin
            @(negedge fclk); n++;
        end
        // allow the slow side to settle beyond the ack return
        repeat (2) @(negedge fclk);
    endtask

    task automatic t_reset();
        check("R1 s_regs", s_regs, '0);
        check("R1 busy", busy, '0);
        check("R1 frozen", frozen, 1'b0);
        check("R1 wr_ready", wr_ready, 1'b1);
    endtask

    task automatic t_single_write();
        int st;
        do_write(1, 32'hA5A5_0001, st);
        @(negedge fclk);
        check("R2 busy set", busy, 4'b0010);
        check("R2 slow not yet", sreg(1), '0);
        wait_idle();
        check("R2 busy clear", busy, '0);
        check("R2 slow value", sreg(1), 32'hA5A5_0001);
    endtask

    task automatic t_stall_and_overlap();
        int st;
        do_write(2, 32'h0000_2222, st);
        do_write(1, 32'h0000_1111, st);
        check("R4 no stall other reg", st, 0);
        do_write(2, 32'h0000_2BBB, st);
        check("R3 stalled", st > 3, 1'b1);
        wait_idle();
        check("R3 last value", sreg(2), 32'h0000_2BBB);
        check("R4 other value", sreg(1), 32'h0000_1111);
    endtask

    task automatic t_freeze_entry();
        int st, bad = 0, n = 0;
        do_write(0, 32'h0000_00F0, st);
        freeze_req = 1'b1;
        @(negedge fclk);
        check("R5 not frozen while busy", frozen, 1'b0);
        while (!frozen && n < 2000) begin
            if (busy == '0 && n > 0) ; // grant may follow on next edge
            @(negedge fclk); n++;
            if (frozen && busy != '0) bad++;
        end
        check("R5 frozen reached", frozen, 1'b1);
        check("R5 busy clear at grant", busy, '0);
        check("R5 no overlap", bad, 0);
        check("R5 entry value", sreg(0), 32'h0000_00F0);
    endtask

    task automatic t_frozen_writes();
        int st, tot = 0;
        do_write(0, 32'h1000_0001, st); tot += st;
        do_write(0, 32'h1000_0002, st); tot += st;
        do_write(0, 32'h1000_0003, st); tot += st;
        do_write(3, 32'h3333_0003, st); tot += st;
        check("R6 no stalls", tot, 0);
        repeat (10) @(negedge sclk);
        @(negedge fclk);
        check("R6 busy clear", busy, '0);
        check("R6 slow reg0 unchanged", sreg(0), 32'h0000_00F0);
        check("R6 slow reg3 unchanged", sreg(3), '0);
    endtask

    task automatic t_release();
        chg0 = -1; chg3 = -1;
        @(negedge fclk);
        freeze_req = 1'b0;
        wr_idx = 2'd1;
        #1;
        check("R7 ready low on release", wr_ready, 1'b0);
        @(negedge fclk);
        check("R7 pending busy", busy, 4'b1001);
        check("R7 frozen cleared", frozen, 1'b0);
        wait_idle();
        repeat (2) @(negedge sclk);
        check("R7 reg0 last", sreg(0), 32'h1000_0003);
        check("R7 reg3", sreg(3), 32'h3333_0003);
        check("R7 same edge", (chg0 == chg3) && (chg0 > 0), 1'b1);
        check("R7 reg1 kept", sreg(1), 32'h0000_1111);
        check("R7 reg2 kept", sreg(2), 32'h0000_2BBB);
    endtask

    task automatic t_empty_release();
        int rose = 0;
        @(negedge fclk); freeze_req = 1'b1;
        repeat (4) @(negedge fclk);
        check("R5 idle grant", frozen, 1'b1);
        freeze_req = 1'b0;
        repeat (20) begin
            @(negedge fclk);
            if (busy != '0) rose++;
        end
        check("R7 empty release no busy", rose, 0);
        check("R7 empty release unfrozen", frozen, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge fclk);
        rst_n = 1'b1;
        @(negedge sclk);
        @(negedge fclk);
        t_reset();
        t_single_write();
        t_stall_and_overlap();
        t_freeze_entry();
        t_frozen_writes();
        t_release();
        t_empty_release();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge fclk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule